// File: doc/BRIEF.md
# Shared-Bus Multi-Digit Display Updater

This controller keeps a row of six latched BCD-to-segment decoders up to date. The decoders share one 4-bit BCD bus. Each decoder has its own latch enable, and those enables come from the parallel outputs of an external 8-bit serial-in shift register. The controller drives three things: the shared bus, the serial data and serial clock lines of that register, and an active-low lamp-test line that forces every segment on. It never multiplexes the digits for display. Every decoder holds its value on its own, and the controller opens one latch at a time only to write it.

After reset the controller lights every segment for a programmable number of clock cycles. During that time it fills the select register with ones, which closes every latch. When lamp-test is released, it refreshes all six digits in one pass. From then on, each one-cycle `tick` pulse refreshes a single digit from the latest input value, and the digit index cycles from 0 to 5.

A write is a walk. One zero is shifted in, followed by enough ones to carry it all the way through the register and out of the far end. The select register has no output holding stage, so that zero opens each latch in turn. While any latch is open, the bus carries that digit's value: the new input value for the target digit, and the value last written for every other digit.

Top module: `digit_bus_updater`

## Requirements
- R1: While `rst_n` is low: `lamp_test_n` = 0, `sel_clk` = 0, `sel_data` = 1 and `bcd_bus` = 0.
- R2: `lamp_test_n` rises on the FLASH_CYCLES-th rising clock edge after reset is released. It then stays high until the next reset.
- R3: While `lamp_test_n` is low, every bit shifted into the select register is 1. Each rising `sel_clk` shifts `sel_data` into output 0 and moves every other output up by one place. A 0 on output d opens the latch of digit d.
- R4: Once lamp-test is released, one walk writes every digit d (bits [4d+3:4d] of `digits_in`) into its decoder. When that walk ends, all select outputs are 1.
- R5: After the start-up refresh, each `tick` pulse rewrites exactly one digit from its current input value. The first digit rewritten is digit 0, then 1 to 5, then 0 again. A tick that arrives before the start-up refresh ends is ignored.
- R6: A latch that is closed never holds anything other than the value last meant for it. Every digit other than the tick's target keeps its value through the walk.
- R7: At no time does more than one digit latch enable (outputs 0 to 5) sit at 0.
- R8: `sel_data` does not change in the clock cycle before a rising `sel_clk` or in the cycle after it. Each high phase of `sel_clk` lasts SCLK_HALF cycles.
- R9: `bcd_bus` never changes in the cycle in which `sel_clk` rises.
- R10: A tick that arrives while a walk is running is held and served once that walk ends. A change on `digits_in` with no tick leaves every displayed value alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse requesting a single-digit refresh |
| digits_in | input | NUM_DIGITS*BCD_WIDTH | Digit values; digit d in bits [4d+3:4d] |
| bcd_bus | output | BCD_WIDTH | Shared BCD bus to all decoders |
| sel_data | output | 1 | Serial data into the select shift register |
| sel_clk | output | 1 | Shift clock of the select shift register |
| lamp_test_n | output | 1 | Active-low all-segments-on control |

## Verification
The assertions assume that `tick` is a single-cycle pulse, that `digits_in` holds still from a tick until its walk has finished, and that SCLK_HALF is at least 2. The bench keeps the digit inputs fixed for 80 or more cycles around every tick. It changes them only while no walk is running, or while it is deliberately testing that an untick'd change has no effect. The bench's behavioural register-and-latch model assumes that the shift register samples data on the rising edge of `sel_clk`, and that a decoder latch follows the bus while its enable is 0.

// File: rtl/digit_bus_pkg.sv
package digit_bus_pkg;

  typedef enum logic [1:0] {
    WALK_FLUSH = 2'd0,
    WALK_ALL   = 2'd1,
    WALK_ONE   = 2'd2
  } walk_kind_e;

  typedef enum logic [2:0] {
    SEQ_FLUSH      = 3'd0,
    SEQ_FLUSH_WAIT = 3'd1,
    SEQ_HOLD       = 3'd2,
    SEQ_INIT       = 3'd3,
    SEQ_INIT_WAIT  = 3'd4,
    SEQ_RUN        = 3'd5
  } seq_state_e;

  // number of shift steps in one walk of the given kind
  function automatic int unsigned walk_steps(walk_kind_e kind, int unsigned sel_w);
    return (kind == WALK_FLUSH) ? sel_w : sel_w + 1;
  endfunction

  // serial bit shifted at a given step: a single 0 opens the first latch
  function automatic logic select_bit(walk_kind_e kind, int unsigned step);
    return !((kind != WALK_FLUSH) && (step == 0));
  endfunction

  function automatic int unsigned next_index(int unsigned idx, int unsigned count);
    return (idx + 1 == count) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/digit_bus_phase.sv
module digit_bus_phase #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic at_load,
  output logic at_rise,
  output logic at_post,
  output logic at_last
);
  localparam int PERIOD = 2 * HALF;
  localparam int PW     = $clog2(PERIOD);

  logic [PW-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                ph_q <= '0;
    else if (!run || ph_q == PW'(PERIOD - 1))  ph_q <= '0;
    else                                       ph_q <= ph_q + 1'b1;
  end

  assign at_load = run && (ph_q == '0);
  assign at_rise = run && (ph_q == PW'(HALF - 1));
  assign at_post = run && (ph_q == PW'(HALF));
  assign at_last = run && (ph_q == PW'(PERIOD - 1));

endmodule

// File: rtl/digit_bus_flash.sv
module digit_bus_flash #(
  parameter int unsigned FLASH_CYCLES = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic released
);
  localparam int CW = $clog2(FLASH_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      released <= 1'b0;
    end else if (!released) begin
      if (cnt_q == CW'(FLASH_CYCLES - 1)) released <= 1'b1;
      else                                cnt_q    <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/digit_bus_walker.sv
module digit_bus_walker
  import digit_bus_pkg::*;
#(
  parameter int ND   = 6,
  parameter int SELW = 8,
  parameter int BW   = 4,
  parameter int HALF = 4,
  parameter int IW   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  walk_kind_e       kind,
  input  logic [IW-1:0]    target,
  input  logic [ND*BW-1:0] digits,
  output logic             busy,
  output logic             done,
  output logic             bus_load,
  output logic             sel_clk,
  output logic             sel_data,
  output logic [BW-1:0]    bus
);
  localparam int SW = $clog2(SELW + 2);

  logic [SW-1:0] step_q;
  walk_kind_e    kind_q;
  logic [IW-1:0] tgt_q;
  logic [BW-1:0] shadow_q [ND];
  logic          at_load, at_rise, at_post, at_last;
  logic [BW-1:0] fresh, held, load_val;
  logic          in_range, last_step;

  digit_bus_phase #(.HALF(HALF)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .at_load(at_load),
    .at_rise(at_rise),
    .at_post(at_post),
    .at_last(at_last)
  );

  always_comb begin
    fresh = '0;
    held  = '0;
    for (int d = 0; d < ND; d++) begin
      if (32'(step_q) == 32'(d)) begin
        fresh = digits[d*BW +: BW];
        held  = shadow_q[d];
      end
    end
  end

  assign in_range  = 32'(step_q) < 32'(ND);
  assign load_val  = (kind_q == WALK_ALL || 32'(tgt_q) == 32'(step_q)) ? fresh : held;
  assign bus_load  = at_post && (kind_q != WALK_FLUSH) && in_range;
  assign last_step = 32'(step_q) == walk_steps(kind_q, 32'(SELW)) - 1;
  assign done      = at_last && last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      kind_q   <= WALK_FLUSH;
      tgt_q    <= '0;
      step_q   <= '0;
      sel_clk  <= 1'b0;
      sel_data <= 1'b1;
      bus      <= '0;
    end else begin
      if (start && !busy) begin
        busy   <= 1'b1;
        kind_q <= kind;
        tgt_q  <= target;
        step_q <= '0;
      end
      if (at_load)  sel_data <= select_bit(kind_q, 32'(step_q));
      if (at_rise)  sel_clk  <= 1'b1;
      if (at_last)  sel_clk  <= 1'b0;
      if (bus_load) bus      <= load_val;
      if (at_last) begin
        if (last_step) busy   <= 1'b0;
        else           step_q <= step_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < ND; d++) shadow_q[d] <= '0;
    end else if (bus_load) begin
      for (int d = 0; d < ND; d++)
        if (32'(step_q) == 32'(d)) shadow_q[d] <= load_val;
    end
  end

endmodule

// File: rtl/digit_bus_updater.sv
module digit_bus_updater
  import digit_bus_pkg::*;
#(
  parameter int          NUM_DIGITS   = 6,
  parameter int          SEL_WIDTH    = 8,
  parameter int          BCD_WIDTH    = 4,
  parameter int          SCLK_HALF    = 4,
  parameter int unsigned FLASH_CYCLES = 100_000_000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            tick,
  input  logic [NUM_DIGITS*BCD_WIDTH-1:0] digits_in,
  output logic [BCD_WIDTH-1:0]            bcd_bus,
  output logic                            sel_data,
  output logic                            sel_clk,
  output logic                            lamp_test_n
);
  localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  seq_state_e    state_q;
  logic [IW-1:0] idx_q;
  logic          pend_q;
  logic          walk_start, walk_busy, walk_done, bus_load, flash_over;
  walk_kind_e    walk_kind;

  digit_bus_flash #(.FLASH_CYCLES(FLASH_CYCLES)) u_flash (
    .clk     (clk),
    .rst_n   (rst_n),
    .released(flash_over)
  );

  assign lamp_test_n = flash_over;

  always_comb begin
    walk_start = 1'b0;
    walk_kind  = WALK_ONE;
    unique case (state_q)
      SEQ_FLUSH: begin walk_start = 1'b1; walk_kind = WALK_FLUSH; end
      SEQ_INIT:  begin walk_start = 1'b1; walk_kind = WALK_ALL;   end
      SEQ_RUN:   walk_start = pend_q && !walk_busy;
      default:   walk_start = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_FLUSH;
      idx_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SEQ_FLUSH:      state_q <= SEQ_FLUSH_WAIT;
        SEQ_FLUSH_WAIT: if (walk_done)  state_q <= SEQ_HOLD;
        SEQ_HOLD:       if (flash_over) state_q <= SEQ_INIT;
        SEQ_INIT:       state_q <= SEQ_INIT_WAIT;
        SEQ_INIT_WAIT:  if (walk_done)  state_q <= SEQ_RUN;
        SEQ_RUN: begin
          if (walk_start) begin
            idx_q  <= IW'(next_index(32'(idx_q), 32'(NUM_DIGITS)));
            pend_q <= tick;
          end else if (tick) begin
            pend_q <= 1'b1;
          end
        end
        default:        state_q <= SEQ_FLUSH;
      endcase
    end
  end

  digit_bus_walker #(
    .ND  (NUM_DIGITS),
    .SELW(SEL_WIDTH),
    .BW  (BCD_WIDTH),
    .HALF(SCLK_HALF),
    .IW  (IW)
  ) u_walker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (walk_start),
    .kind    (walk_kind),
    .target  (idx_q),
    .digits  (digits_in),
    .busy    (walk_busy),
    .done    (walk_done),
    .bus_load(bus_load),
    .sel_clk (sel_clk),
    .sel_data(sel_data),
    .bus     (bcd_bus)
  );

endmodule

// File: rtl/digit_bus_updater_chk.sv
module digit_bus_updater_chk #(
  parameter int NUM_DIGITS = 6,
  parameter int SEL_WIDTH  = 8,
  parameter int BCD_WIDTH  = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sel_clk,
  input logic                 sel_data,
  input logic [BCD_WIDTH-1:0] bcd_bus,
  input logic                 lamp_test_n,
  input logic                 bus_load
);
  // observed image of the external select register, plus which stages hold a known bit
  logic [SEL_WIDTH-1:0] sr_seen, known_seen;
  logic                 clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_seen    <= '1;
      known_seen <= '0;
      clk_prev   <= 1'b0;
    end else begin
      clk_prev <= sel_clk;
      if (sel_clk && !clk_prev) begin
        sr_seen    <= {sr_seen[SEL_WIDTH-2:0], sel_data};
        known_seen <= {known_seen[SEL_WIDTH-2:0], 1'b1};
      end
    end
  end

  assert_lamp_stays_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test_n |=> lamp_test_n);

  assert_no_select_in_lamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp_test_n && $rose(sel_clk)) |-> sel_data);

  assert_bus_after_lamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_load |-> lamp_test_n);

  assert_single_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sr_seen[NUM_DIGITS-1:0] & known_seen[NUM_DIGITS-1:0]) <= 1);

  assert_data_setup_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_clk) |-> $stable(sel_data));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_clk) |=> $stable(sel_data));

  assert_bus_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_clk) |-> $stable(bcd_bus));

endmodule

bind digit_bus_updater digit_bus_updater_chk #(
  .NUM_DIGITS(NUM_DIGITS),
  .SEL_WIDTH (SEL_WIDTH),
  .BCD_WIDTH (BCD_WIDTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_clk    (sel_clk),
  .sel_data   (sel_data),
  .bcd_bus    (bcd_bus),
  .lamp_test_n(lamp_test_n),
  .bus_load   (bus_load)
);

// File: tb/digit_bus_updater_test.sv
`timescale 1ns/1ps
module digit_bus_updater_test;
  localparam int ND = 6, SW = 8, BW = 4, HALF = 3, FLASH = 200;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [ND*BW-1:0] din;
  logic [BW-1:0] bcd_bus;
  logic sel_data, sel_clk, lamp_test_n;
  int compared = 0, mismatched = 0;

  always #2.5 clk = ~clk;

  digit_bus_updater #(
    .NUM_DIGITS(ND), .SEL_WIDTH(SW), .BCD_WIDTH(BW),
    .SCLK_HALF(HALF), .FLASH_CYCLES(FLASH)
  ) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .digits_in(din),
    .bcd_bus(bcd_bus), .sel_data(sel_data), .sel_clk(sel_clk),
    .lamp_test_n(lamp_test_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic logic [ND*BW-1:0] pattern(input int v);
    logic [ND*BW-1:0] r;
    for (int d = 0; d < ND; d++) r[d*BW +: BW] = BW'((v * 7 + d * 3) % 10);
    return r;
  endfunction

  // behavioural model of the external select register and decoder latches
  logic [SW-1:0] m_sr = '1, m_known = '0;
  logic [BW-1:0] m_lat [ND];
  logic [BW-1:0] exp_v [ND];
  logic [BW-1:0] old_v [ND];
  bit            maybe [ND];
  bit            armed = 0;
  logic          p_clk = 1'b0, p_data = 1'b1, rose_prev = 1'b0;
  logic [BW-1:0] p_bus = '0;
  int            hi_len = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_known = '0; p_clk = 1'b0; p_data = 1'b1; p_bus = '0; rose_prev = 1'b0; hi_len = 0;
    end else begin
      bit rose;
      int open_n;
      rose = sel_clk && !p_clk;
      if (rose_prev) check(sel_data == p_data, "R8 data hold", sel_data, p_data);
      if (rose) begin
        check(sel_data == p_data, "R8 data setup", sel_data, p_data);
        check(bcd_bus == p_bus, "R9 bus steady at shift", bcd_bus, p_bus);
        if (!lamp_test_n) check(sel_data == 1'b1, "R3 ones during lamp", sel_data, 1);
        m_sr    = {m_sr[SW-2:0], sel_data};
        m_known = {m_known[SW-2:0], 1'b1};
      end
      if (sel_clk) hi_len++;
      else if (p_clk) begin
        check(hi_len == HALF, "R8 high phase", hi_len, HALF);
        hi_len = 0;
      end
      open_n = 0;
      for (int d = 0; d < ND; d++) begin
        if (m_known[d] && !m_sr[d]) begin
          m_lat[d] = bcd_bus;
          open_n++;
        end else if (armed && m_known[d]) begin
          bit ok;
          ok = (m_lat[d] == exp_v[d]) || (maybe[d] && m_lat[d] == old_v[d]);
          check(ok, "R6 closed latch", m_lat[d], exp_v[d]);
        end
      end
      if (&m_known) check(open_n <= 1, "R7 open latches", open_n, 1);
      rose_prev = rose;
      p_clk = sel_clk; p_data = sel_data; p_bus = bcd_bus;
    end
  end

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic expect_digit(input int k);
    old_v[k] = exp_v[k];
    exp_v[k] = din[k*BW +: BW];
    maybe[k] = 1;
  endtask

  initial begin
    int n;
    int k;
    for (int d = 0; d < ND; d++) begin maybe[d] = 0; exp_v[d] = '0; old_v[d] = '0; end
    din = pattern(0);
    repeat (3) @(negedge clk);
    check(lamp_test_n == 1'b0, "R1 lamp in reset", lamp_test_n, 0);
    check(sel_clk == 1'b0, "R1 sel_clk in reset", sel_clk, 0);
    check(sel_data == 1'b1, "R1 sel_data in reset", sel_data, 1);
    check(bcd_bus == '0, "R1 bus in reset", bcd_bus, 0);
    rst_n = 1'b1;
    n = 0;
    while (!lamp_test_n && n < 5000) begin
      @(posedge clk);
      n++;
      #1;
      tick = (n == 40);   // R5: tick during lamp-test must be ignored
    end
    tick = 1'b0;
    check(n == FLASH, "R2 lamp duration", n, FLASH);
    repeat (150) @(negedge clk);
    check(m_sr == '1, "R4 all latches closed", m_sr, 255);
    for (int d = 0; d < ND; d++) begin
      check(m_lat[d] == din[d*BW +: BW], "R4 start-up refresh", m_lat[d], din[d*BW +: BW]);
      exp_v[d] = din[d*BW +: BW];
    end
    armed = 1;
    // R10: inputs change without a tick
    din = pattern(5);
    repeat (60) @(negedge clk);
    for (int d = 0; d < ND; d++)
      check(m_lat[d] == exp_v[d], "R10 no tick no change", m_lat[d], exp_v[d]);
    // R5 / R6: one digit per tick, cyclic from 0
    k = 0;
    for (int t = 0; t < 8; t++) begin
      din = pattern(t + 2);
      @(negedge clk);
      expect_digit(k);
      pulse_tick();
      repeat (80) @(negedge clk);
      for (int d = 0; d < ND; d++) begin
        if (d == k) check(m_lat[d] == exp_v[d], "R5 target digit", m_lat[d], exp_v[d]);
        else        check(m_lat[d] == exp_v[d], "R6 other digit kept", m_lat[d], exp_v[d]);
      end
      maybe[k] = 0;
      k = (k + 1) % ND;
    end
    // R10: second tick while the first walk is running
    din = pattern(20);
    @(negedge clk);
    expect_digit(k);
    expect_digit((k + 1) % ND);
    pulse_tick();
    @(negedge clk);
    pulse_tick();
    repeat (160) @(negedge clk);
    check(m_lat[k] == exp_v[k], "R10 first queued tick", m_lat[k], exp_v[k]);
    check(m_lat[(k+1)%ND] == exp_v[(k+1)%ND], "R10 held tick served",
          m_lat[(k+1)%ND], exp_v[(k+1)%ND]);
    maybe[k] = 0;
    maybe[(k+1)%ND] = 0;
    check(lamp_test_n == 1'b1, "R2 lamp stays released", lamp_test_n, 1);
    check(m_sr == '1, "R7 idle all closed", m_sr, 255);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule